// File: doc/BRIEF.md
# Maskable Interrupt Priority Arbiter

This block decides, on every clock, whether one of several maskable interrupt sources may be taken by the processor and, if so, which one. Each source has a pending bit, set by a request input, and a 3-bit priority level. The processor side holds a 3-bit current priority threshold and a global enable flag. A source qualifies when the flag is set, its pending bit is set and its level is strictly above the threshold. Among the qualifying sources the highest level wins. When levels are equal, the lowest index wins.

Writes to the threshold and to the per-source levels do not reach the decision at once. A threshold written on the exception-return path is used after a two-cycle delay. A threshold written on the direct load path is used after a three-cycle delay. A level write is used after a two-cycle delay. The enable flag takes effect at the next edge. The processor samples a one-cycle accept pulse that carries the winning index. The winner's pending bit then clears by itself.

Top module: `irq_level_arbiter`

## Requirements
- R1: After a synchronous active-low reset, the threshold is 0, the enable flag is 0, every level is 0, no source is pending and `acc_valid` is low.
- R2: A source is accepted only when the enable flag is 1, the source is pending and its level is greater than the threshold. When a source is pending and already eligible, writing the flag to 1 at edge k gives an accept pulse at edge k+1.
- R3: A source whose level equals the threshold is never accepted.
- R4: A source at level 0 is never accepted. A threshold of 7 blocks every source.
- R5: Among eligible sources, the one with the highest level wins. On a tie of levels, the lowest index wins.
- R6: A threshold written on the return path (`ipl_ret_wr`) at edge k appears on `ipl_cur` at edge k+2 and is used from then on.
- R7: A threshold written on the load path (`ipl_ld_wr`) at edge k appears on `ipl_cur` at edge k+3 and is used from then on.
- R8: A level write at edge k is used by the decision from edge k+2. A pending, enabled source raised above the threshold this way is accepted at edge k+3, and not earlier.
- R9: `acc_valid` is high for exactly one cycle. No accept is registered in the cycle after a pulse. The winner's pending bit clears at the edge after the pulse, so the source is not accepted again unless it is requested again.
- R10: When a return-path update and a load-path update mature at the same edge, the one issued later (the return-path write) sets the threshold.
- R11: The enable flag, the pending bits, the levels and the threshold are independent. Writing the flag or a level leaves the threshold and the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gie_wr | input | 1 | Write strobe for the global enable flag |
| gie_wdata | input | 1 | New enable flag value |
| ipl_ret_wr | input | 1 | Threshold write on the return path (2-cycle delay) |
| ipl_ret_data | input | 3 | Threshold value for the return path |
| ipl_ld_wr | input | 1 | Threshold write on the load path (3-cycle delay) |
| ipl_ld_data | input | 3 | Threshold value for the load path |
| lvl_wr | input | 1 | Per-source level write strobe (2-cycle delay) |
| lvl_sel | input | IDX_W | Index of the source whose level is written |
| lvl_data | input | 3 | New level, where 0 disables the source |
| req_set | input | NSRC | Per-source request pulses that set the pending bits |
| acc_valid | output | 1 | One-cycle accept pulse |
| acc_idx | output | IDX_W | Index of the accepted source |
| ipl_cur | output | 3 | Threshold currently used by the decision |

## Verification
The hardest case to reach is two threshold updates on different paths that mature at the same edge. The bench issues a load-path write and then, one cycle later, a return-path write, so that both land together. It then issues both paths in the same cycle, so that they land one edge apart, and reads `ipl_cur` at each edge. Delayed level writes are checked in a similar way. A source is left pending below or at the threshold, and then its level is raised. The scoreboard expects the accept at exactly the third edge, so an accept one edge early is caught.

// File: rtl/irq_arb_pkg.sv
// Package irq_arb_pkg
// Holds the shared level type and the helper that compares a level with the threshold.
// Assumes that levels and the threshold have the same width.
package irq_arb_pkg;
    localparam int LVL_W   = 3;
    localparam int LVL_MAX = (1 << LVL_W) - 1;

    typedef logic [LVL_W-1:0] lvl_t;

    // Returns 1 when a source level is strictly above the threshold.
    function automatic logic lvl_above(input lvl_t lvl, input lvl_t thr);
        return lvl > thr;
    endfunction
endpackage

// File: rtl/irq_upd_delay.sv
// Module irq_upd_delay
// Fixed-latency shift line for a register update with a valid bit.
// An update captured at edge k leaves the last stage after edge k+DEPTH-1,
// so a register fed from out_* takes the new value at edge k+DEPTH.
// Assumes DEPTH >= 1. Only the valid bits are reset.
module irq_upd_delay #(
    parameter int DEPTH = 2,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);
    logic [DEPTH-1:0] vld_sr;
    logic [W-1:0]     dat_sr [DEPTH];

    // First stage captures the update strobe and its data.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr[0] <= 1'b0;
        else        vld_sr[0] <= in_vld;
        dat_sr[0] <= in_dat;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        // Each later stage moves the update forward by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) vld_sr[g] <= 1'b0;
            else        vld_sr[g] <= vld_sr[g-1];
            dat_sr[g] <= dat_sr[g-1];
        end
    end

    assign out_vld = vld_sr[DEPTH-1];
    assign out_dat = dat_sr[DEPTH-1];
endmodule

// File: rtl/irq_prio_pick.sv
// Module irq_prio_pick
// Combinational winner selection. Among the eligible sources it returns the one
// with the highest level; on equal levels the lowest index is kept.
// Assumes that eligibility (enable, pending, level above threshold) is already applied.
module irq_prio_pick import irq_arb_pkg::*; #(
    parameter int NSRC  = 8,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  elig,
    input  lvl_t             lvl [NSRC],
    output logic             win_vld,
    output logic [IDX_W-1:0] win_idx,
    output lvl_t             win_lvl
);
    // Scan upward and replace the current best only on a strictly greater level.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!win_vld || lvl[i] > win_lvl)) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_arbiter.sv
// Module irq_level_arbiter (top)
// Maskable interrupt acceptance. Holds the pending bits, the per-source levels,
// the enable flag and the threshold. Threshold and level updates pass through
// fixed delay lines. The accept decision is registered as a one-cycle pulse,
// and the winner's pending bit clears on the following edge.
// Assumes NSRC >= 2. A request in the same cycle as a clear wins.
module irq_level_arbiter import irq_arb_pkg::*; #(
    parameter int NSRC    = 8,
    parameter int RET_DLY = 2,
    parameter int LD_DLY  = 3,
    parameter int LVL_DLY = 2,
    localparam int IDX_W  = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gie_wr,
    input  logic             gie_wdata,
    input  logic             ipl_ret_wr,
    input  logic [LVL_W-1:0] ipl_ret_data,
    input  logic             ipl_ld_wr,
    input  logic [LVL_W-1:0] ipl_ld_data,
    input  logic             lvl_wr,
    input  logic [IDX_W-1:0] lvl_sel,
    input  logic [LVL_W-1:0] lvl_data,
    input  logic [NSRC-1:0]  req_set,
    output logic             acc_valid,
    output logic [IDX_W-1:0] acc_idx,
    output logic [LVL_W-1:0] ipl_cur
);
    // When both threshold paths mature together, the path with the shorter
    // delay was issued later and must win.
    localparam bit RET_FIRST = (RET_DLY <= LD_DLY);

    logic             gie_q;
    lvl_t             ipl_q;
    lvl_t             lvl_q [NSRC];
    logic [NSRC-1:0]  pend_q;

    logic             ret_vld, ld_vld, lw_vld;
    lvl_t             ret_dat, ld_dat;
    logic [IDX_W+LVL_W-1:0] lw_dat;
    logic [IDX_W-1:0] lw_idx;
    lvl_t             lw_lvl;

    logic [NSRC-1:0]  elig;
    logic             pick_vld;
    logic [IDX_W-1:0] pick_idx;
    lvl_t             pick_lvl;

    irq_upd_delay #(.DEPTH(RET_DLY), .W(LVL_W)) u_ret_dly (
        .clk(clk), .rst_n(rst_n), .in_vld(ipl_ret_wr), .in_dat(ipl_ret_data),
        .out_vld(ret_vld), .out_dat(ret_dat)
    );

    irq_upd_delay #(.DEPTH(LD_DLY), .W(LVL_W)) u_ld_dly (
        .clk(clk), .rst_n(rst_n), .in_vld(ipl_ld_wr), .in_dat(ipl_ld_data),
        .out_vld(ld_vld), .out_dat(ld_dat)
    );

    irq_upd_delay #(.DEPTH(LVL_DLY), .W(IDX_W+LVL_W)) u_lvl_dly (
        .clk(clk), .rst_n(rst_n), .in_vld(lvl_wr), .in_dat({lvl_sel, lvl_data}),
        .out_vld(lw_vld), .out_dat(lw_dat)
    );

    assign lw_idx = lw_dat[IDX_W+LVL_W-1:LVL_W];
    assign lw_lvl = lw_dat[LVL_W-1:0];

    // Global enable flag: a direct write, used from the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (gie_wr) gie_q <= gie_wdata;
    end

    // Threshold register: takes whichever delayed update matures, and the later-issued one on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q <= '0;
        end else if (RET_FIRST) begin
            if (ret_vld)     ipl_q <= ret_dat;
            else if (ld_vld) ipl_q <= ld_dat;
        end else begin
            if (ld_vld)      ipl_q <= ld_dat;
            else if (ret_vld) ipl_q <= ret_dat;
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // Per-source level: updated when a delayed write for this index matures.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 lvl_q[s] <= '0;
            else if (lw_vld && lw_idx == IDX_W'(s))     lvl_q[s] <= lw_lvl;
        end

        // Per-source pending bit: set by a request, cleared the edge after its accept pulse.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 pend_q[s] <= 1'b0;
            else if (req_set[s])                        pend_q[s] <= 1'b1;
            else if (acc_valid && acc_idx == IDX_W'(s)) pend_q[s] <= 1'b0;
        end

        // Eligibility: enabled, pending, strictly above the threshold, and not in the pulse cycle.
        assign elig[s] = gie_q && pend_q[s] && !acc_valid && lvl_above(lvl_q[s], ipl_q);
    end

    irq_prio_pick #(.NSRC(NSRC)) u_pick (
        .elig(elig), .lvl(lvl_q),
        .win_vld(pick_vld), .win_idx(pick_idx), .win_lvl(pick_lvl)
    );

    // Accept pulse register: one cycle per decision, and the index is held between pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_idx   <= '0;
        end else begin
            acc_valid <= pick_vld;
            if (pick_vld) acc_idx <= pick_idx;
        end
    end

    assign ipl_cur = ipl_q;

    // An accept requires the enable flag in the deciding cycle.
    p_gie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(gie_q));

    // The winning level was strictly above the threshold when it was chosen.
    p_strict_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ($past(pick_lvl) > $past(ipl_q)));

    // A threshold of 7 leaves nothing to pick.
    p_top_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl_q == lvl_t'(LVL_MAX)) |-> !pick_vld);

    // The pulse lasts one cycle.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);

    // The winner's pending bit is gone after the pulse unless it is requested again.
    p_clear_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !req_set[acc_idx]) |=> !pend_q[$past(acc_idx)]);

    // The threshold changes only when a delayed update matures.
    p_ipl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_vld && !ld_vld) |=> $stable(ipl_q));
endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
    localparam int NSRC = 8;
    localparam int IW   = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            gie_wr = 1'b0, gie_wdata = 1'b0;
    logic            ipl_ret_wr = 1'b0, ipl_ld_wr = 1'b0, lvl_wr = 1'b0;
    logic [2:0]      ipl_ret_data = '0, ipl_ld_data = '0, lvl_data = '0;
    logic [IW-1:0]   lvl_sel = '0;
    logic [NSRC-1:0] req_set = '0;
    logic            acc_valid;
    logic [IW-1:0]   acc_idx;
    logic [2:0]      ipl_cur;

    irq_level_arbiter #(.NSRC(NSRC)) u_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata),
        .ipl_ret_wr(ipl_ret_wr), .ipl_ret_data(ipl_ret_data),
        .ipl_ld_wr(ipl_ld_wr), .ipl_ld_data(ipl_ld_data),
        .lvl_wr(lvl_wr), .lvl_sel(lvl_sel), .lvl_data(lvl_data),
        .req_set(req_set),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .ipl_cur(ipl_cur)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0, acc_seen = 0;
    bit done = 1'b0;

    typedef struct { int cyc; int idx; string req; } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_acc(int c, int i, string req);
        exp_t e;
        e.cyc = c; e.idx = i; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: every accept pulse must match the head of the scoreboard, and no expectation may be missed.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (acc_valid) begin
                acc_seen++;
                if (sb_q.size() == 0) begin
                    chk("R2/R3/R4/R9 unexpected accept, idx", int'(acc_idx), -1);
                end else begin
                    mon_e = sb_q.pop_front();
                    chk({mon_e.req, " accept cycle"}, cyc, mon_e.cyc);
                    chk({mon_e.req, " accept index"}, int'(acc_idx), mon_e.idx);
                end
            end else if (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                mon_e = sb_q.pop_front();
                chk({mon_e.req, " missing accept"}, 0, 1);
            end
        end
    end

    // Each driver task returns, at the negedge after it, the edge k at which its strobe was sampled.
    task automatic wr_gie(bit v, output int k);
        @(negedge clk); k = cyc + 1; gie_wr = 1'b1; gie_wdata = v;
        @(negedge clk); gie_wr = 1'b0;
    endtask
    task automatic wr_ret(int v, output int k);
        @(negedge clk); k = cyc + 1; ipl_ret_wr = 1'b1; ipl_ret_data = 3'(v);
        @(negedge clk); ipl_ret_wr = 1'b0;
    endtask
    task automatic wr_ld(int v, output int k);
        @(negedge clk); k = cyc + 1; ipl_ld_wr = 1'b1; ipl_ld_data = 3'(v);
        @(negedge clk); ipl_ld_wr = 1'b0;
    endtask
    task automatic wr_lvl(int s, int v, output int k);
        @(negedge clk); k = cyc + 1; lvl_wr = 1'b1; lvl_sel = IW'(s); lvl_data = 3'(v);
        @(negedge clk); lvl_wr = 1'b0;
    endtask
    task automatic req(logic [NSRC-1:0] m, output int k);
        @(negedge clk); k = cyc + 1; req_set = m;
        @(negedge clk); req_set = '0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k, snap;
        // R1: reset state
        idle(3);
        chk("R1 acc_valid in reset", int'(acc_valid), 0);
        chk("R1 ipl_cur in reset", int'(ipl_cur), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 acc_valid after reset", int'(acc_valid), 0);
        chk("R1 ipl_cur after reset", int'(ipl_cur), 0);

        // R2: pending and eligible but the flag is off, so nothing happens until the flag is set
        wr_lvl(2, 3, k);
        idle(2);
        req(8'b0000_0100, k);
        snap = acc_seen;
        idle(4);
        chk("R2 no accept with flag 0", acc_seen, snap);
        wr_gie(1'b1, k);
        expect_acc(k + 1, 2, "R2");
        idle(4);

        // R7: load-path threshold reaches ipl_cur at edge k+3
        wr_ld(3, k);
        idle(2);
        chk("R7 ipl before k+3", int'(ipl_cur), 0);
        idle(1);
        chk("R7 ipl at k+3", int'(ipl_cur), 3);

        // R3: a level equal to the threshold is not taken
        wr_lvl(1, 3, k);
        idle(2);
        req(8'b0000_0010, k);
        snap = acc_seen;
        idle(4);
        chk("R3 equal level not accepted", acc_seen, snap);

        // R8: raise the pending source's level; the accept comes at edge k+3 exactly
        wr_lvl(1, 4, k);
        expect_acc(k + 3, 1, "R8");
        idle(5);

        // R6: return-path threshold reaches ipl_cur at edge k+2
        wr_ret(1, k);
        idle(1);
        chk("R6 ipl before k+2", int'(ipl_cur), 3);
        idle(1);
        chk("R6 ipl at k+2", int'(ipl_cur), 1);

        // R5, R9: tie at level 6 between src3 and src5, then src0 at level 2; one idle cycle between pulses
        wr_lvl(5, 6, k);
        wr_lvl(3, 6, k);
        wr_lvl(0, 2, k);
        idle(2);
        req(8'b0010_1001, k);
        expect_acc(k + 1, 3, "R5 tie lowest index");
        expect_acc(k + 3, 5, "R5/R9 second after gap");
        expect_acc(k + 5, 0, "R5/R9 lowest level last");
        idle(8);
        snap = acc_seen;
        idle(3);
        chk("R9 no re-accept after clear", acc_seen, snap);

        // R4: level 0 is never taken; threshold 7 blocks a level-7 source
        req(8'b0100_0000, k);
        snap = acc_seen;
        idle(4);
        chk("R4 level 0 not accepted", acc_seen, snap);
        wr_ret(7, k);
        idle(2);
        chk("R4 ipl now 7", int'(ipl_cur), 7);
        wr_lvl(7, 7, k);
        idle(2);
        req(8'b1000_0000, k);
        idle(5);
        chk("R4 threshold 7 masks all", acc_seen, snap);

        // R10: load at k and return at k+1 mature together; the return write wins
        wr_gie(1'b0, k);
        @(negedge clk); k = cyc + 1; ipl_ld_wr = 1'b1; ipl_ld_data = 3'd5;
        @(negedge clk); ipl_ld_wr = 1'b0; ipl_ret_wr = 1'b1; ipl_ret_data = 3'd2;
        @(negedge clk); ipl_ret_wr = 1'b0;
        idle(1);
        chk("R10 ipl at k+2", int'(ipl_cur), 7);
        idle(1);
        chk("R10 later return write wins", int'(ipl_cur), 2);
        // R6/R7 both paths written in the same cycle land one edge apart
        @(negedge clk); k = cyc + 1;
        ipl_ret_wr = 1'b1; ipl_ret_data = 3'd4; ipl_ld_wr = 1'b1; ipl_ld_data = 3'd6;
        @(negedge clk); ipl_ret_wr = 1'b0; ipl_ld_wr = 1'b0;
        idle(2);
        chk("R6 return value at k+2", int'(ipl_cur), 4);
        idle(1);
        chk("R7 load value at k+3", int'(ipl_cur), 6);

        // R11: the flag write leaves src7 pending and the threshold intact
        wr_gie(1'b1, k);
        expect_acc(k + 1, 7, "R11 pending kept across flag writes");
        chk("R11 ipl unchanged by flag write", int'(ipl_cur), 6);
        idle(3);
        // R11: the level write leaves src6 pending; it is taken once its level is used
        wr_lvl(6, 7, k);
        expect_acc(k + 3, 6, "R11/R8 pending kept across level writes");
        chk("R11 ipl unchanged by level write", int'(ipl_cur), 6);
        idle(6);
        chk("R9 scoreboard drained", sb_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule